// File: doc/BRIEF.md
# SPI Master with Selectable Transfer Attribute Sets

This block is a full-duplex SPI master. Software first loads up to eight transfer profiles. Each profile holds a frame length, a clock polarity, a clock phase and a baud divider. Every command pushed into the block carries:

- a data word;
- the index of the profile to use;
- a mask of the chip selects to drive;
- a continue bit, which can keep the selects low into the next frame.

Commands wait in a four-entry transmit queue. Received words collect in a four-entry receive queue, which software reads from its head.

For each frame the block drives SCK, MOSI and six active-low chip selects, and it samples MISO. Bits leave MSB first. The received word is right-justified, with its upper bits cleared. A single-cycle end-of-frame pulse marks the moment the received word enters the receive queue. A command cannot start while the receive queue is full, so no received data is ever lost. A command pushed into a full transmit queue is discarded, and a sticky overflow flag records the loss.

Top module: `spi_attr_master`

## Requirements
- R1: After reset all chip selects are high (`cs_n` = 6'h3F), SCK is low, both queue levels are 0, and `eot` and `tx_ovf` are 0.
- R2: A write with `attr_we` high stores the frame size, CPOL, CPHA and divider into the set addressed by `attr_sel`. Each command uses the set named by its `cmd_attr` field.
- R3: The frame length is `fsz`+1 bits for `fsz` from 3 to 15. Values 0 to 2 give 4 bits. A frame of N bits produces exactly 2N SCK transitions.
- R4: Each SCK half-period, and the delay from chip-select assertion to the first SCK edge, lasts (`div`+1)×2 clocks. Between frames SCK rests at the selected CPOL.
- R5: Data leaves MSB first. The received word is the N bits from MISO, right-justified, with bits above N-1 zero. With MISO tied to MOSI it equals the transmitted low N bits.
- R6: With CPHA=0, MOSI changes only on trailing SCK edges and is sampled on leading edges. With CPHA=1, MOSI changes only on leading edges and is sampled on trailing edges. A leading edge is one that moves SCK away from CPOL.
- R7: During a frame `cs_n` equals the inverted command mask. When the selects are released they stay high for at least one SCK half-period.
- R8: When a finished frame's continue bit is set, the next command is already queued, and the receive queue has at least two free entries, the next frame starts with no release of the chip selects.
- R9: The transmit queue holds four commands. A push while it is full is dropped and sets `tx_ovf`, which stays set until reset.
- R10: No command starts while the receive queue holds four words. The command waits in the transmit queue until a pop frees space.
- R11: `eot` is high for exactly one clock per completed frame. In the following cycle the receive level includes the new word.
- R12: Received words leave the receive queue in completion order. `rx_data` always shows the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attr_we | input | 1 | Write strobe for an attribute set |
| attr_sel | input | 3 | Attribute set being written |
| attr_fsz | input | 4 | Frame size minus one |
| attr_cpol | input | 1 | SCK idle level |
| attr_cpha | input | 1 | Clock phase selection |
| attr_div | input | 4 | Baud divider |
| cmd_push | input | 1 | Push a command into the transmit queue |
| cmd_data | input | 16 | Transmit word, right-justified |
| cmd_attr | input | 3 | Attribute set used by the command |
| cmd_cs | input | 6 | Chip selects to assert, active-high mask |
| cmd_cont | input | 1 | Keep the selects asserted into the next frame |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 16 | Head of the receive queue |
| tx_level | output | 3 | Entries in the transmit queue |
| rx_level | output | 3 | Entries in the receive queue |
| tx_ovf | output | 1 | Sticky transmit overflow flag |
| eot | output | 1 | One-cycle end-of-frame pulse |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 6 | Active-low chip selects |

## Verification
The bound checker watches several properties on every cycle:

- queue levels never exceed four;
- an overflow push sets the flag, and the flag stays set;
- the end-of-frame pulse is always a single cycle and is followed by a non-empty receive queue;
- the transmit queue is never drained while the receive queue is full.

Frame length, half-period timing, phase behaviour, bit order, right-justification and chip-select chaining can only be shown by the bench scenarios. The bench sweeps all eight profiles with a MISO loopback, both straight and inverted. It measures every SCK interval, notes which edges move MOSI, and compares each received word with a value computed from the requirements.

// File: rtl/spi_am_pkg.sv
package spi_am_pkg;
  localparam int DATA_W = 16;
  localparam int CS_W   = 6;
  localparam int ATTR_N = 8;
  localparam int ATTR_IW = $clog2(ATTR_N);
  localparam int FSZ_W  = 4;
  localparam int DIV_W  = 4;
  localparam int MIN_BITS = 4;

  typedef struct packed {
    logic [FSZ_W-1:0] fsz;
    logic             cpol;
    logic             cpha;
    logic [DIV_W-1:0] div;
  } attr_t;

  typedef struct packed {
    logic [DATA_W-1:0]  data;
    logic [ATTR_IW-1:0] sel;
    logic [CS_W-1:0]    cs;
    logic               cont;
  } cmd_t;

  localparam int CMD_W = $bits(cmd_t);
endpackage

// File: rtl/spi_am_fifo.sv
module spi_am_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          do_wr, do_rd;

  assign do_wr = push && (cnt_q != LW'(DEPTH));
  assign do_rd = pop && (cnt_q != '0);

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_wr) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_rd) rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wp_q] <= din;
  end

  assign dout  = mem_q[rp_q];
  assign level = cnt_q;
endmodule

// File: rtl/spi_am_attr_bank.sv
module spi_am_attr_bank
  import spi_am_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [ATTR_IW-1:0] wsel,
  input  attr_t              wdata,
  input  logic [ATTR_IW-1:0] rsel,
  output attr_t              rdata
);
  attr_t bank_q [ATTR_N];

  generate
    for (genvar g = 0; g < ATTR_N; g++) begin : g_set
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          bank_q[g] <= '0;
        else if (we && wsel == ATTR_IW'(g))  bank_q[g] <= wdata;
      end
    end
  endgenerate

  assign rdata = bank_q[rsel];
endmodule

// File: rtl/spi_am_engine.sv
module spi_am_engine
  import spi_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [CS_W-1:0]   cmd_cs,
  input  logic              cmd_cont,
  input  attr_t             attr,
  input  logic              rx_room,
  input  logic              rx_room2,
  output logic              cmd_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [CS_W-1:0]   cs_n
);
  localparam int NB_W  = $clog2(DATA_W + 1);
  localparam int EG_W  = $clog2(2 * DATA_W);
  localparam int CNT_W = DIV_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TRAIL, S_GAP} st_t;

  st_t               st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, half_q, half_d;
  logic [EG_W-1:0]   edge_q, edge_d, last_e;
  logic [NB_W-1:0]   nb_q, nb_d, ld_nb;
  logic [DATA_W-1:0] sr_q, sr_d, rx_q, rx_d, ld_sr;
  logic [CS_W-1:0]   cs_q, cs_d;
  logic              cpha_q, cpha_d, cont_q, cont_d;
  logic              mosi_q, mosi_d, sck_q, sck_d;
  logic              load, done, odd, smp, drv;

  // frame length: fsz+1 bits, small codes clamp to the minimum (R3)
  assign ld_nb  = (attr.fsz < FSZ_W'(MIN_BITS - 1)) ? NB_W'(MIN_BITS)
                                                     : NB_W'(attr.fsz) + 1'b1;
  assign ld_sr  = cmd_data << (NB_W'(DATA_W) - ld_nb);   // MSB-align (R5)
  assign last_e = EG_W'(2 * nb_q - 1);
  assign odd    = edge_q[0];
  assign smp    = cpha_q ? odd : !odd;                          // R6
  assign drv    = cpha_q ? !odd : (odd && (edge_q != last_e));  // R6

  always_comb begin
    st_d   = st_q;   cnt_d  = cnt_q;  half_d = half_q; edge_d = edge_q;
    nb_d   = nb_q;   sr_d   = sr_q;   rx_d   = rx_q;   cs_d   = cs_q;
    cpha_d = cpha_q; cont_d = cont_q; mosi_d = mosi_q; sck_d  = sck_q;
    load   = 1'b0;
    done   = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (cmd_valid && rx_room) load = 1'b1;                  // R10
      end
      S_SHIFT: begin
        if (cnt_q == '0) begin
          cnt_d  = half_q;
          edge_d = edge_q + 1'b1;
          sck_d  = !sck_q;
          if (smp) rx_d = {rx_q[DATA_W-2:0], miso};
          if (drv) begin
            mosi_d = sr_q[DATA_W-1];
            sr_d   = sr_q << 1;
          end
          if (edge_q == last_e) st_d = S_TRAIL;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_TRAIL: begin
        if (cnt_q == '0) begin
          done = 1'b1;
          if (cont_q && cmd_valid && rx_room2) begin            // R8
            load = 1'b1;
          end else begin
            cs_d  = '0;                                         // R7
            cnt_d = half_q;
            st_d  = S_GAP;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        if (cnt_q == '0) st_d = S_IDLE;
        else             cnt_d = cnt_q - 1'b1;
      end
    endcase
    if (load) begin
      st_d   = S_SHIFT;
      half_d = {attr.div, 1'b1};                                // R4
      cnt_d  = {attr.div, 1'b1};
      edge_d = '0;
      nb_d   = ld_nb;
      rx_d   = '0;
      cs_d   = cmd_cs;
      cont_d = cmd_cont;
      cpha_d = attr.cpha;
      sck_d  = attr.cpol;
      if (attr.cpha) begin
        sr_d = ld_sr;
      end else begin
        mosi_d = ld_sr[DATA_W-1];
        sr_d   = ld_sr << 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE; cnt_q  <= '0;   half_q <= '0;   edge_q <= '0;
      nb_q   <= '0;     sr_q   <= '0;   rx_q   <= '0;   cs_q   <= '0;
      cpha_q <= 1'b0;   cont_q <= 1'b0; mosi_q <= 1'b0; sck_q  <= 1'b0;
    end else begin
      st_q   <= st_d;   cnt_q  <= cnt_d;  half_q <= half_d; edge_q <= edge_d;
      nb_q   <= nb_d;   sr_q   <= sr_d;   rx_q   <= rx_d;   cs_q   <= cs_d;
      cpha_q <= cpha_d; cont_q <= cont_d; mosi_q <= mosi_d; sck_q  <= sck_d;
    end
  end

  assign cmd_pop = load;
  assign rx_push = done;
  assign rx_word = rx_q;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign cs_n    = ~cs_q;
endmodule

// File: rtl/spi_attr_master.sv
module spi_attr_master
  import spi_am_pkg::*;
#(
  parameter int  FIFO_DEPTH = 4,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               attr_we,
  input  logic [ATTR_IW-1:0] attr_sel,
  input  logic [FSZ_W-1:0]   attr_fsz,
  input  logic               attr_cpol,
  input  logic               attr_cpha,
  input  logic [DIV_W-1:0]   attr_div,
  input  logic               cmd_push,
  input  logic [DATA_W-1:0]  cmd_data,
  input  logic [ATTR_IW-1:0] cmd_attr,
  input  logic [CS_W-1:0]    cmd_cs,
  input  logic               cmd_cont,
  input  logic               rx_pop,
  output logic [DATA_W-1:0]  rx_data,
  output logic [LVL_W-1:0]   tx_level,
  output logic [LVL_W-1:0]   rx_level,
  output logic               tx_ovf,
  output logic               eot,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic [CS_W-1:0]    cs_n
);
  cmd_t              push_cmd, head_cmd;
  logic [CMD_W-1:0]  head_raw;
  attr_t             wr_attr, cur_attr;
  logic              tx_full, cmd_pop, rx_push, ovf_q, ovf_d;
  logic [DATA_W-1:0] rx_word;

  assign push_cmd = '{data: cmd_data, sel: cmd_attr, cs: cmd_cs, cont: cmd_cont};
  assign head_cmd = cmd_t'(head_raw);
  assign wr_attr  = '{fsz: attr_fsz, cpol: attr_cpol, cpha: attr_cpha, div: attr_div};
  assign tx_full  = (tx_level == LVL_W'(FIFO_DEPTH));

  spi_am_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(cmd_push), .din(push_cmd),
    .pop(cmd_pop), .dout(head_raw), .level(tx_level)
  );

  spi_am_attr_bank u_bank (
    .clk(clk), .rst_n(rst_n), .we(attr_we), .wsel(attr_sel), .wdata(wr_attr),
    .rsel(head_cmd.sel), .rdata(cur_attr)
  );

  spi_am_engine u_eng (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(tx_level != '0), .cmd_data(head_cmd.data),
    .cmd_cs(head_cmd.cs), .cmd_cont(head_cmd.cont), .attr(cur_attr),
    .rx_room(rx_level != LVL_W'(FIFO_DEPTH)),
    .rx_room2(rx_level < LVL_W'(FIFO_DEPTH - 1)),
    .cmd_pop(cmd_pop), .rx_push(rx_push), .rx_word(rx_word),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  spi_am_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word),
    .pop(rx_pop), .dout(rx_data), .level(rx_level)
  );

  // sticky overflow on a push into a full queue (R9)
  assign ovf_d = ovf_q || (cmd_push && tx_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign tx_ovf = ovf_q;
  assign eot    = rx_push;   // R11
endmodule

// File: rtl/spi_am_chk.sv
module spi_am_chk #(
  parameter int  FIFO_DEPTH = 4,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_push,
  input logic             rx_pop,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_ovf,
  input logic             eot
);
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(FIFO_DEPTH)) && (rx_level <= LVL_W'(FIFO_DEPTH))); // R9
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_push && tx_level == LVL_W'(FIFO_DEPTH)) |=> tx_ovf); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> tx_ovf); // R9
  AST_NO_START_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == LVL_W'(FIFO_DEPTH)) |=> (tx_level >= $past(tx_level))); // R10
  AST_EOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> !eot); // R11
  AST_EOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    eot |=> (rx_level != '0)); // R11
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !eot && rx_level == '0) |=> (rx_level == '0)); // R12
endmodule

bind spi_attr_master spi_am_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .rx_pop(rx_pop),
  .tx_level(tx_level), .rx_level(rx_level), .tx_ovf(tx_ovf), .eot(eot)
);

// File: tb/sim_spi_attr_master.sv
`timescale 1ns/1ps
module sim_spi_attr_master;
  logic        clk, rst_n;
  logic        attr_we, attr_cpol, attr_cpha;
  logic [2:0]  attr_sel, cmd_attr;
  logic [3:0]  attr_fsz, attr_div;
  logic        cmd_push, cmd_cont, rx_pop;
  logic [15:0] cmd_data, rx_data;
  logic [5:0]  cmd_cs, cs_n;
  logic [2:0]  tx_level, rx_level;
  logic        tx_ovf, eot, sck, mosi, miso, inv;

  int n_run = 0, n_fail = 0;

  assign miso = mosi ^ inv;

  spi_attr_master u0 (
    .clk(clk), .rst_n(rst_n), .attr_we(attr_we), .attr_sel(attr_sel),
    .attr_fsz(attr_fsz), .attr_cpol(attr_cpol), .attr_cpha(attr_cpha),
    .attr_div(attr_div), .cmd_push(cmd_push), .cmd_data(cmd_data),
    .cmd_attr(cmd_attr), .cmd_cs(cmd_cs), .cmd_cont(cmd_cont), .rx_pop(rx_pop),
    .rx_data(rx_data), .tx_level(tx_level), .rx_level(rx_level), .tx_ovf(tx_ovf),
    .eot(eot), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #10 clk = !clk;

  // ---- profile table and expected arithmetic ----
  function automatic int p_fsz(int i);
    case (i)
      0: return 1;  1: return 3;  2: return 7;  3: return 15;
      4: return 11; 5: return 4;  6: return 9;  default: return 15;
    endcase
  endfunction
  function automatic int p_div(int i); return (i * 3) % 4; endfunction
  function automatic int nbits(int f); return (f < 3) ? 4 : f + 1; endfunction
  function automatic int halfp(int d); return (d + 1) * 2; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---- bus monitor ----
  int cyc = 0, last_ev = 0, idle_at = 0, exp_h = 2;
  bit exp_cpol = 0;
  int m_edges = 0, m_fr_edges = 0, m_bad = 0, m_mlead = 0, m_mtrail = 0;
  int m_rel = 0, m_gap = 1000, m_eots = 0, m_eotbad = 0;
  logic [5:0] m_cs = '1;
  bit p_sck = 0, p_mosi = 0, p_act = 0, p_eot = 0;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst_n) begin
      automatic bit act = (cs_n != 6'h3F);
      if (act && !p_act) begin
        last_ev = cyc;
        if (cyc - idle_at < m_gap) m_gap = cyc - idle_at;
      end else if (sck != p_sck) begin
        if (cyc - last_ev != exp_h) m_bad++;
        last_ev = cyc;
        m_edges++;
        if (mosi != p_mosi) begin
          if (sck != exp_cpol) m_mlead++;
          else                 m_mtrail++;
        end
      end
      if (!act && p_act) begin m_rel++; idle_at = cyc; end
      if (eot) begin
        m_fr_edges = m_edges; m_edges = 0; m_cs = cs_n; m_eots++;
        last_ev = cyc + 1;
        if (p_eot) m_eotbad++;
      end
      p_act = act; p_eot = eot;
    end
    p_sck = sck; p_mosi = mosi;
  end

  task automatic mon_clear();
    m_edges = 0; m_fr_edges = 0; m_bad = 0; m_mlead = 0; m_mtrail = 0;
    m_rel = 0; m_gap = 1000;
  endtask

  task automatic push(input logic [15:0] d, input int a, input logic [5:0] cs, input bit c);
    @(negedge clk);
    cmd_push = 1'b1; cmd_data = d; cmd_attr = 3'(a); cmd_cs = cs; cmd_cont = c;
    @(negedge clk);
    cmd_push = 1'b0;
  endtask

  task automatic wait_rx(input int n);
    for (int t = 0; t < 5000 && rx_level < 3'(n); t++) @(negedge clk);
  endtask

  task automatic pop1();
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  int frames = 0;

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; attr_we = 0; attr_sel = 0; attr_fsz = 0; attr_cpol = 0;
    attr_cpha = 0; attr_div = 0; cmd_push = 0; cmd_data = 0; cmd_attr = 0;
    cmd_cs = 0; cmd_cont = 0; rx_pop = 0; inv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 6'h3F, "R1 cs_n", cs_n, 6'h3F);
    chk(sck == 1'b0, "R1 sck", sck, 0);
    chk(tx_level == 0 && rx_level == 0, "R1 levels", {tx_level, rx_level}, 0);
    chk(eot == 0 && tx_ovf == 0, "R1 flags", {eot, tx_ovf}, 0);

    // R2 program all eight sets
    for (int i = 0; i < 8; i++) begin
      attr_we = 1; attr_sel = 3'(i); attr_fsz = 4'(p_fsz(i));
      attr_cpol = i[0]; attr_cpha = i[1]; attr_div = 4'(p_div(i));
      @(negedge clk);
    end
    attr_we = 0;

    // sweep: every set, three patterns, straight and inverted loopback
    for (int i = 0; i < 8; i++) begin
      for (int p = 0; p < 3; p++) begin
        automatic int n = nbits(p_fsz(i));
        automatic logic [15:0] d = (p == 0) ? (16'hA5C3 ^ 16'(i * 16'h1111)) :
                                   (p == 1) ? 16'hFFFF : (16'h0001 << i);
        automatic logic [15:0] m = 16'((32'h1 << n) - 1);
        automatic logic [15:0] e;
        automatic logic [5:0] cs = 6'b1 << ((i + p) % 6);
        inv = p[0];
        e = (inv ? ~d : d) & m;
        exp_h = halfp(p_div(i)); exp_cpol = i[0];
        mon_clear();
        push(d, i, cs, 1'b0);
        wait_rx(1);
        frames++;
        chk(rx_data == e, $sformatf("R5 set%0d data", i), rx_data, e);
        chk(m_fr_edges == 2 * n, $sformatf("R3 set%0d edges", i), m_fr_edges, 2 * n);
        chk(m_bad == 0, $sformatf("R4 set%0d halfperiod", i), m_bad, 0);
        chk(m_cs == ~cs, $sformatf("R7 set%0d cs", i), m_cs, ~cs);
        chk(sck == exp_cpol, $sformatf("R4 set%0d idle sck", i), sck, exp_cpol);
        if (i[1]) chk(m_mtrail == 0, $sformatf("R6 set%0d cpha1", i), m_mtrail, 0);
        else      chk(m_mlead == 0, $sformatf("R6 set%0d cpha0", i), m_mlead, 0);
        pop1();
        repeat (2 * exp_h + 4) @(negedge clk);
      end
    end
    inv = 0;

    // R8 chained frames keep the selects low
    exp_h = halfp(p_div(2)); exp_cpol = 0;
    mon_clear();
    push(16'h0011, 2, 6'b000100, 1'b1);
    push(16'h0022, 2, 6'b000100, 1'b1);
    push(16'h0033, 2, 6'b000100, 1'b0);
    wait_rx(3);
    repeat (2 * exp_h + 4) @(negedge clk);
    frames += 3;
    chk(m_rel == 1, "R8 single release", m_rel, 1);
    chk(m_bad == 0, "R4 chained timing", m_bad, 0);
    for (int k = 1; k <= 3; k++) begin
      chk(rx_data == 16'(k * 16'h11), "R12 order", rx_data, k * 16'h11);
      pop1();
    end

    // R7 unchained frames release with a gap
    mon_clear();
    push(16'h0044, 2, 6'b100000, 1'b0);
    push(16'h0055, 2, 6'b100000, 1'b0);
    wait_rx(2);
    repeat (2 * exp_h + 4) @(negedge clk);
    frames += 2;
    chk(m_rel == 2, "R7 two releases", m_rel, 2);
    chk(m_gap >= exp_h, "R7 gap", m_gap, exp_h);
    pop1(); pop1();

    // R10 / R9 receive-full stall and overflow
    exp_h = halfp(p_div(0)); exp_cpol = 0;
    for (int k = 1; k <= 4; k++) push(16'(k), 0, 6'b000001, 1'b0);
    wait_rx(4);
    repeat (20) @(negedge clk);
    for (int k = 5; k <= 8; k++) push(16'(k), 0, 6'b000001, 1'b0);
    repeat (40) @(negedge clk);
    chk(tx_level == 4, "R10 stalled tx", tx_level, 4);
    chk(cs_n == 6'h3F, "R10 no start", cs_n, 6'h3F);
    chk(tx_ovf == 0, "R9 no ovf yet", tx_ovf, 0);
    push(16'h9, 0, 6'b000001, 1'b0);
    chk(tx_ovf == 1, "R9 ovf set", tx_ovf, 1);
    chk(tx_level == 4, "R9 dropped", tx_level, 4);
    for (int k = 1; k <= 8; k++) begin
      wait_rx(1);
      chk(rx_data == 16'(k), "R12 drain order", rx_data, k);
      pop1();
    end
    frames += 8;
    repeat (60) @(negedge clk);
    chk(rx_level == 0 && tx_level == 0, "R9 dropped word absent", {tx_level, rx_level}, 0);
    chk(tx_ovf == 1, "R9 sticky", tx_ovf, 1);
    chk(m_eots == frames, "R11 eot count", m_eots, frames);
    chk(m_eotbad == 0, "R11 eot width", m_eotbad, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule